// File: doc/BRIEF.md
# Strobed Handshake Port Controller

This block moves bytes between a CPU and a slow parallel peripheral over one 8-bit data port. Every transfer is paced by a three-wire handshake. The port works in one of two directions, chosen by a configuration input.

In the input direction, the peripheral places data on the pins and pulls its active-low strobe. The block then latches the pins and raises a buffer-full flag. When the strobe is released while the buffer is still full, the block raises an interrupt request. A CPU read collects the byte and clears both the flag and the interrupt.

In the output direction, a CPU write loads the output latch and pulls the active-low output-buffer-full line. The peripheral takes the byte and pulses its active-low acknowledge. The falling edge of the acknowledge releases output-buffer-full. The rising edge raises the interrupt request, which tells the CPU to send the next byte. Interrupts are raised only while the interrupt-enable input is high.

All peripheral-side control lines are asynchronous to the block clock. They pass through a synchronizer before their edges are detected, so a pin edge takes effect on the third rising clock edge after it appears.

Top module: `hs_port_ctrl`

## Requirements
- R1: While reset is applied and just after it, buffer-full (`ibf`) is 0, `obf_n` is 1, `intr` is 0 and `pin_oe` is 0, which is the input direction.
- R2: With `cfg_dir_in`=1, a falling edge on `stb_n` latches `pin_in` into the input register and sets `ibf`. The input register is read on `cpu_rdata` while `cfg_dir_in`=1.
- R3: `ibf` is set only as a result of a detected falling edge of `stb_n`.
- R4: A rising edge of `stb_n` raises `intr` when `ibf` is set and `irq_en`=1. With `irq_en`=0, `intr` stays 0.
- R5: A one-cycle `cpu_rd` pulse in the input direction clears `ibf` and `intr` on the following clock edge. During the read, `cpu_rdata` shows the latched byte.
- R6: A second strobe while `ibf` is still set overwrites the input register, and `ibf` stays set.
- R7: A read and a strobe falling edge may fall in the same cycle. In that case the read returns the old byte, `ibf` stays set, and the input register takes the new byte.
- R8: With `cfg_dir_in`=0, a `cpu_wr` pulse loads `cpu_wdata` onto `pin_out`, drives `obf_n` to 0 and clears `intr` on the following clock edge.
- R9: In the output direction, a falling edge of `ack_n` sets `obf_n` to 1. A rising edge of `ack_n` raises `intr` when `irq_en`=1.
- R10: A CPU write may fall in the same cycle as an `ack_n` rising edge. In that case the write wins: `obf_n` is 0, `intr` is 0, and `pin_out` carries the new byte.
- R11: Writes in the input direction leave `pin_out` and the flags unchanged. Strobes in the output direction leave `ibf` and the input register unchanged.
- R12: A change of `cfg_dir_in` clears `ibf` and `intr` and sets `obf_n` to 1 on the next clock edge. One cycle after the change, `pin_oe` is 1 for the output direction and 0 for the input direction.
- R13: `intr` rises only while `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_dir_in | input | 1 | 1 = input direction, 0 = output direction |
| irq_en | input | 1 | Interrupt enable |
| cpu_rd | input | 1 | One-cycle CPU read strobe |
| cpu_wr | input | 1 | One-cycle CPU write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Input register (input direction) or output latch (output direction) |
| pin_in | input | 8 | Data pins as driven by the peripheral |
| pin_out | output | 8 | Output latch toward the pins |
| pin_oe | output | 1 | Pin drive enable, high in the output direction |
| stb_n | input | 1 | Peripheral strobe, active low |
| ibf | output | 1 | Input buffer full |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| obf_n | output | 1 | Output buffer full, active low |
| intr | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same clock edge. The first pair is a CPU read and a synchronized strobe falling edge in the input direction. The second pair is a CPU write and a synchronized acknowledge rising edge in the output direction. The bench provokes each by raising the CPU strobe exactly two falling clock edges after the pin edge, so that the CPU strobe spans the edge on which the synchronized event is acted on. It then judges the outcome at the ports. For the read, it checks that the old byte was returned and that the flag and new byte survive. For the write, it checks that output-buffer-full stays low and that the interrupt stays clear.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned HS_DATA_W   = 8;
  localparam int unsigned HS_SYNC_DEF = 2;

  typedef enum logic {
    HS_DIR_OUT = 1'b0,
    HS_DIR_IN  = 1'b1
  } hs_dir_e;

  typedef struct packed {
    logic full;
    logic irq;
  } hs_flags_t;
endpackage

// File: rtl/hs_rst_sync.sv
module hs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sh
      if (i == 0) begin : g_first
        assign sh_d[i] = 1'b1;
      end else begin : g_next
        assign sh_d[i] = sh_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_ns = sh_q[STAGES-1];
endmodule

// File: rtl/hs_edge_sync.sv
module hs_edge_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign chain_d[i] = din;
      end else begin : g_tail
        assign chain_d[i] = chain_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{IDLE}};
      last_q  <= IDLE;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign fall = last_q & ~chain_q[STAGES-1];
  assign rise = ~last_q & chain_q[STAGES-1];
endmodule

// File: rtl/hs_in_chan.sv
module hs_in_chan
  import hs_pkg::*;
#(
  parameter int unsigned W = HS_DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         clr,
  input  logic         irq_en,
  input  logic         rd,
  input  logic         stb_fall,
  input  logic         stb_rise,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] data_q,
  output logic         full,
  output logic         irq
);
  hs_flags_t f_q, f_d;
  logic      ld_en;

  always_comb begin
    f_d   = f_q;
    ld_en = 1'b0;
    if (clr) begin
      f_d.full = 1'b0;
      f_d.irq  = 1'b0;
    end else if (active) begin
      if (rd) begin
        f_d.full = 1'b0;
        f_d.irq  = 1'b0;
      end
      if (stb_rise && f_q.full && irq_en && !rd) begin
        f_d.irq = 1'b1;
      end
      if (stb_fall) begin
        f_d.full = 1'b1;
        ld_en    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (ld_en) data_q <= pin_in;
  end

  assign full = f_q.full;
  assign irq  = f_q.irq;
endmodule

// File: rtl/hs_out_chan.sv
module hs_out_chan
  import hs_pkg::*;
#(
  parameter int unsigned W = HS_DATA_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic         clr,
  input  logic         irq_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         ack_fall,
  input  logic         ack_rise,
  output logic [W-1:0] data_q,
  output logic         full,
  output logic         irq
);
  hs_flags_t f_q, f_d;
  logic      ld_en;

  always_comb begin
    f_d   = f_q;
    ld_en = 1'b0;
    if (clr) begin
      f_d.full = 1'b0;
      f_d.irq  = 1'b0;
    end else if (active) begin
      if (ack_fall) f_d.full = 1'b0;
      if (ack_rise && irq_en) f_d.irq = 1'b1;
      if (wr) begin
        f_d.full = 1'b1;
        f_d.irq  = 1'b0;
        ld_en    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     data_q <= '0;
    else if (ld_en) data_q <= wdata;
  end

  assign full = f_q.full;
  assign irq  = f_q.irq;
endmodule

// File: rtl/hs_port_ctrl.sv
module hs_port_ctrl
  import hs_pkg::*;
#(
  parameter int unsigned W           = HS_DATA_W,
  parameter int unsigned SYNC_STAGES = HS_SYNC_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_dir_in,
  input  logic         irq_en,
  input  logic         cpu_rd,
  input  logic         cpu_wr,
  input  logic [W-1:0] cpu_wdata,
  output logic [W-1:0] cpu_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic         pin_oe,
  input  logic         stb_n,
  output logic         ibf,
  input  logic         ack_n,
  output logic         obf_n,
  output logic         intr
);
  localparam int unsigned RST_STAGES = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;

  logic    rst_ns;
  hs_dir_e dir_q, dir_d, dir_req;
  logic    mode_clr, in_act, out_act;
  logic    stb_fall, stb_rise, ack_fall, ack_rise;
  logic [W-1:0] in_data, out_data;
  logic    in_full, in_irq, out_full, out_irq;

  hs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  hs_edge_sync #(.STAGES(RST_STAGES), .IDLE(1'b1)) u_stb_sync (
    .clk(clk), .rst_n(rst_ns), .din(stb_n), .fall(stb_fall), .rise(stb_rise)
  );

  hs_edge_sync #(.STAGES(RST_STAGES), .IDLE(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_ns), .din(ack_n), .fall(ack_fall), .rise(ack_rise)
  );

  assign dir_req  = cfg_dir_in ? HS_DIR_IN : HS_DIR_OUT;
  assign mode_clr = (dir_req != dir_q);
  assign in_act   = (dir_req == HS_DIR_IN)  && !mode_clr;
  assign out_act  = (dir_req == HS_DIR_OUT) && !mode_clr;

  always_comb begin
    dir_d = dir_req;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) dir_q <= HS_DIR_IN;
    else         dir_q <= dir_d;
  end

  hs_in_chan #(.W(W)) u_in (
    .clk(clk), .rst_n(rst_ns), .active(in_act), .clr(mode_clr),
    .irq_en(irq_en), .rd(cpu_rd), .stb_fall(stb_fall), .stb_rise(stb_rise),
    .pin_in(pin_in), .data_q(in_data), .full(in_full), .irq(in_irq)
  );

  hs_out_chan #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_ns), .active(out_act), .clr(mode_clr),
    .irq_en(irq_en), .wr(cpu_wr), .wdata(cpu_wdata),
    .ack_fall(ack_fall), .ack_rise(ack_rise),
    .data_q(out_data), .full(out_full), .irq(out_irq)
  );

  assign cpu_rdata = (dir_req == HS_DIR_IN) ? in_data : out_data;
  assign pin_out   = out_data;
  assign pin_oe    = (dir_q == HS_DIR_OUT);
  assign ibf       = in_full;
  assign obf_n     = ~out_full;
  assign intr      = in_irq | out_irq;
endmodule

// File: rtl/hs_port_chk.sv
module hs_port_chk (
  input logic clk,
  input logic rst_ns,
  input logic cfg_dir_in,
  input logic irq_en,
  input logic cpu_rd,
  input logic cpu_wr,
  input logic stb_fall,
  input logic mode_clr,
  input logic ibf,
  input logic obf_n,
  input logic intr
);
  // R3
  ibf_from_strobe_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(ibf) |-> $past(stb_fall));

  // R5
  rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cpu_rd && cfg_dir_in && !mode_clr && !stb_fall) |=> (!ibf && !intr));

  // R8
  wr_loads_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cpu_wr && !cfg_dir_in && !mode_clr) |=> (!obf_n && !intr));

  // R11
  out_dir_no_ibf_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ibf && !cfg_dir_in) |=> !ibf);

  // R12
  mode_change_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    mode_clr |=> (!ibf && obf_n && !intr));

  // R13
  intr_enable_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(intr) |-> $past(irq_en));
endmodule

bind hs_port_ctrl hs_port_chk u_chk (
  .clk(clk), .rst_ns(rst_ns), .cfg_dir_in(cfg_dir_in), .irq_en(irq_en),
  .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .stb_fall(stb_fall), .mode_clr(mode_clr),
  .ibf(ibf), .obf_n(obf_n), .intr(intr)
);

// File: tb/sim_hs_port_ctrl.sv
module sim_hs_port_ctrl;
  logic       clk = 1'b0;
  logic       rst_n, cfg_dir_in, irq_en, cpu_rd, cpu_wr;
  logic [7:0] cpu_wdata, cpu_rdata, pin_in, pin_out;
  logic       pin_oe, stb_n, ibf, ack_n, obf_n, intr;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #2 clk = ~clk;

  hs_port_ctrl #(.W(8), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dir_in(cfg_dir_in), .irq_en(irq_en),
    .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .stb_n(stb_n), .ibf(ibf),
    .ack_n(ack_n), .obf_n(obf_n), .intr(intr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic stb_low(input logic [7:0] d);
    @(negedge clk); pin_in = d; stb_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic stb_high();
    @(negedge clk); stb_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic ack_pulse_low();
    @(negedge clk); ack_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic ack_release();
    @(negedge clk); ack_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic cpu_read(output logic [7:0] v);
    @(negedge clk); cpu_rd = 1'b1; #1 v = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic cpu_write(input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cfg_dir_in = 1'b1; irq_en = 1'b0; cpu_rd = 1'b0; cpu_wr = 1'b0;
    cpu_wdata = '0; pin_in = '0; stb_n = 1'b1; ack_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ibf in reset", ibf, 0);
    chk("R1 obf_n in reset", obf_n, 1);
    chk("R1 intr in reset", intr, 0);
    chk("R1 pin_oe in reset", pin_oe, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ibf after reset", ibf, 0);
    chk("R1 obf_n after reset", obf_n, 1);
  endtask

  task automatic t_in_basic();
    logic [7:0] v;
    irq_en = 1'b1;
    stb_low(8'hA5);
    chk("R2 ibf set by strobe", ibf, 1);
    chk("R2 latched data", cpu_rdata, 8'hA5);
    chk("R4 no intr before strobe release", intr, 0);
    stb_high();
    chk("R4 intr on strobe release", intr, 1);
    cpu_read(v);
    chk("R5 read returns byte", v, 8'hA5);
    chk("R5 ibf cleared by read", ibf, 0);
    chk("R5 intr cleared by read", intr, 0);
  endtask

  task automatic t_in_noirq();
    logic [7:0] v;
    irq_en = 1'b0;
    stb_low(8'h3C);
    stb_high();
    chk("R4 ibf set with irq disabled", ibf, 1);
    chk("R4 intr stays low when disabled", intr, 0);
    cpu_read(v);
    chk("R4 data with irq disabled", v, 8'h3C);
    irq_en = 1'b1;
  endtask

  task automatic t_overwrite();
    logic [7:0] v;
    stb_low(8'h11); stb_high();
    stb_low(8'h22); stb_high();
    chk("R6 ibf still set", ibf, 1);
    chk("R6 data overwritten", cpu_rdata, 8'h22);
    cpu_read(v);
    chk("R6 read after overwrite", v, 8'h22);
  endtask

  task automatic t_collide_in();
    logic [7:0] v;
    stb_low(8'h44); stb_high();
    @(negedge clk); pin_in = 8'h55; stb_n = 1'b0;
    @(negedge clk);
    @(negedge clk); cpu_rd = 1'b1; #1 v = cpu_rdata;
    @(negedge clk); cpu_rd = 1'b0;
    chk("R7 read returns old byte", v, 8'h44);
    chk("R7 ibf stays set", ibf, 1);
    chk("R7 new byte latched", cpu_rdata, 8'h55);
    stb_high();
    cpu_read(v);
    chk("R7 later read gets new byte", v, 8'h55);
  endtask

  task automatic t_out_basic();
    @(negedge clk); cfg_dir_in = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 pin_oe high in output dir", pin_oe, 1);
    chk("R12 obf_n idle after switch", obf_n, 1);
    cpu_write(8'h5A);
    chk("R8 pin_out loaded", pin_out, 8'h5A);
    chk("R8 obf_n asserted", obf_n, 0);
    chk("R8 intr clear after write", intr, 0);
    ack_pulse_low();
    chk("R9 obf_n released by ack", obf_n, 1);
    chk("R9 no intr before ack release", intr, 0);
    ack_release();
    chk("R9 intr on ack release", intr, 1);
    cpu_write(8'h6B);
    chk("R8 write clears intr", intr, 0);
    chk("R8 second byte on pins", pin_out, 8'h6B);
    ack_pulse_low(); ack_release();
  endtask

  task automatic t_collide_out();
    chk("R10 intr set before collision", intr, 1);
    cpu_write(8'h77);
    ack_pulse_low();
    @(negedge clk); ack_n = 1'b1;
    @(negedge clk);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = 8'h88;
    @(negedge clk); cpu_wr = 1'b0;
    chk("R10 obf_n low, write wins", obf_n, 0);
    chk("R10 intr low, write wins", intr, 0);
    chk("R10 new byte on pins", pin_out, 8'h88);
    repeat (3) @(negedge clk);
    chk("R10 intr stays low", intr, 0);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    stb_low(8'h99); stb_high();
    chk("R11 strobe ignored in output dir", ibf, 0);
    cpu_read(v);
    chk("R11 read leaves obf_n in output dir", obf_n, 0);
    @(negedge clk); cfg_dir_in = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 obf_n idle after switch", obf_n, 1);
    chk("R12 intr clear after switch", intr, 0);
    chk("R12 pin_oe low in input dir", pin_oe, 0);
    chk("R11 input register untouched", cpu_rdata, 8'h55);
    cpu_write(8'hAA);
    repeat (2) @(negedge clk);
    chk("R11 write ignored in input dir", pin_out, 8'h88);
    chk("R11 ibf unchanged by write", ibf, 0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_in_basic();
    t_in_noirq();
    t_overwrite();
    t_collide_in();
    t_out_basic();
    t_collide_out();
    t_ignore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule